// File: doc/BRIEF.md
# DMA Channel Bus-Request Arbiter

This block sits between an interrupt controller and a processor bus interface. It serves four DMA channels. Each channel has a transfer-request line from the interrupt controller and an acknowledge line back to it. A per-channel control bit decides which of two processor bus-request outputs the channel uses. One output asks for the bus with snooping and the other asks for it without.

While the bus is idle, the arbiter looks at the snooping group first. It picks the lowest-numbered pending channel of that group. If that group has nothing pending, it does the same for the non-snooping group. It then raises the matching request output and waits for the processor's grant. On the first cycle the grant is seen, it pulses the winner's acknowledge. It keeps the request asserted until the winner reports that its transfer is done. During that time, no channel of either type can take the bus.

After a transfer completes, the request output stays low for at least one cycle before the next arbitration. The channel's snoop bit is sampled only when arbitration takes place.

Top module: `dma_bus_arbiter`

## Requirements
- R1: A synchronous active-high reset, including one applied during a transfer, drives both request outputs and all acknowledge bits to 0 on the next clock edge.
- R2: A winner whose `snoop_sel` bit is 1 asserts `bus_req_snp`, and a winner whose bit is 0 asserts `bus_req_plain`; the two outputs are never high together.
- R3: Within one request group, the lowest-numbered pending channel wins (channel 0 highest, channel 3 lowest).
- R4: When no transfer is active and both groups have pending channels, a snooping-group channel wins, even over a lower-numbered non-snooping channel.
- R5: The request output rises one clock edge after the idle arbiter samples a pending channel, and it stays high until the winner's `xfer_done` bit is sampled, with or without grant.
- R6: `chan_ack` is one-hot on bit n of the winner for exactly one cycle. It rises on the edge after the first grant sample.
- R7: Once a winner holds the request, a new request of the other type changes neither request output nor the acknowledge target until that transfer completes.
- R8: An `xfer_done` pulse on a channel other than the current winner is ignored, and the request stays asserted.
- R9: The request output falls on the edge that samples the winner's done. It stays low for at least one further cycle, so a new request appears no earlier than two edges after the done sample.
- R10: No acknowledge is issued while `bus_grant` has not been sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | 4 | Per-channel transfer request from the interrupt controller |
| snoop_sel | input | 4 | Per-channel request type: 1 = snooping, 0 = plain |
| xfer_done | input | 4 | Per-channel transfer-complete pulse |
| bus_grant | input | 1 | Bus grant from the processor |
| bus_req_snp | output | 1 | Bus request with snooping |
| bus_req_plain | output | 1 | Bus request without snooping |
| chan_ack | output | 4 | Per-channel acknowledge to the interrupt controller |

## Verification
Every output is registered, so each result is due exactly one rising edge after the input that causes it. A request appears one edge after `chan_req` is driven, and an acknowledge appears one edge after `bus_grant` is driven. A request falls one edge after the winner's `xfer_done`, and a new arbitration result appears no earlier than the second edge after it. The bench drives inputs 1 ns after a rising edge and checks outputs after each following edge. Each expectation is therefore tied to a counted number of edges, and an extra or missing pipeline stage shows up as a mismatch.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_HOLD = 2'd2,
    ARB_GAP  = 2'd3
  } arb_state_t;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    valid = |req;
  end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snp_valid,
  input  logic [IW-1:0] snp_idx,
  input  logic          pln_valid,
  input  logic [IW-1:0] pln_idx,
  input  logic [N-1:0]  xfer_done,
  input  logic          bus_grant,
  output logic          req_snp,
  output logic          req_pln,
  output logic [N-1:0]  ack
);
  arb_state_t    st_q;
  logic [IW-1:0] win_q;
  logic          win_done;
  logic          req_any;

  assign win_done = xfer_done[win_q];
  assign req_any  = req_snp | req_pln;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ARB_IDLE;
      win_q   <= '0;
      req_snp <= 1'b0;
      req_pln <= 1'b0;
      ack     <= '0;
    end else begin
      ack <= '0;
      case (st_q)
        ARB_IDLE: begin
          if (snp_valid) begin
            win_q   <= snp_idx;
            req_snp <= 1'b1;
            st_q    <= ARB_WAIT;
          end else if (pln_valid) begin
            win_q   <= pln_idx;
            req_pln <= 1'b1;
            st_q    <= ARB_WAIT;
          end
        end
        ARB_WAIT: begin
          if (bus_grant) begin
            ack  <= N'(1) << win_q;
            st_q <= ARB_HOLD;
          end
        end
        ARB_HOLD: begin
          if (win_done) begin
            req_snp <= 1'b0;
            req_pln <= 1'b0;
            st_q    <= ARB_GAP;
          end
        end
        ARB_GAP:  st_q <= ARB_IDLE;
        default:  st_q <= ARB_IDLE;
      endcase
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    !(req_snp && req_pln)); // R2
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack)); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    (|ack) |=> !(|ack)); // R6
  AST_ACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    ((|ack) && !$past(rst)) |-> $past(bus_grant)); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    ($fell(req_any) && !$past(rst)) |-> $past(|xfer_done)); // R5
  AST_GAP_LOW: assert property (@(posedge clk) disable iff (rst)
    ($fell(req_any) && !$past(rst)) |=> !req_any); // R9
  AST_TYPE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (req_snp && !$past(rst) && $past(req_any)) |-> $past(req_snp)); // R7
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] snoop_sel,
  input  logic [NCH-1:0] xfer_done,
  input  logic           bus_grant,
  output logic           bus_req_snp,
  output logic           bus_req_plain,
  output logic [NCH-1:0] chan_ack
);
  logic [1:0]          grp_valid;
  logic [1:0][IW-1:0]  grp_idx;
  logic [1:0][NCH-1:0] grp_req;

  assign grp_req[0] = chan_req & snoop_sel;
  assign grp_req[1] = chan_req & ~snoop_sel;

  for (genvar g = 0; g < 2; g++) begin : g_grp
    prio_pick #(.N(NCH)) u_pick (
      .req   (grp_req[g]),
      .valid (grp_valid[g]),
      .idx   (grp_idx[g])
    );
  end

  arb_ctrl #(.N(NCH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .snp_valid (grp_valid[0]),
    .snp_idx   (grp_idx[0]),
    .pln_valid (grp_valid[1]),
    .pln_idx   (grp_idx[1]),
    .xfer_done (xfer_done),
    .bus_grant (bus_grant),
    .req_snp   (bus_req_snp),
    .req_pln   (bus_req_plain),
    .ack       (chan_ack)
  );
endmodule

// File: tb/test_dma_bus_arbiter.sv
`timescale 1ns/1ps
module test_dma_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] chan_req = '0;
  logic [3:0] snoop_sel = '0;
  logic [3:0] xfer_done = '0;
  logic       bus_grant = 1'b0;
  logic       bus_req_snp, bus_req_plain;
  logic [3:0] chan_ack;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_bus_arbiter i_dma_bus_arbiter (
    .clk(clk), .rst(rst), .chan_req(chan_req), .snoop_sel(snoop_sel),
    .xfer_done(xfer_done), .bus_grant(bus_grant),
    .bus_req_snp(bus_req_snp), .bus_req_plain(bus_req_plain),
    .chan_ack(chan_ack)
  );

  // {chan_req, snoop_sel, expect snooping request, expected winner}
  localparam logic [10:0] VEC [8] = '{
    {4'b0001, 4'b0000, 1'b0, 2'd0},
    {4'b1000, 4'b1000, 1'b1, 2'd3},
    {4'b0110, 4'b0000, 1'b0, 2'd1},
    {4'b1010, 4'b1000, 1'b1, 2'd3},
    {4'b1111, 4'b0101, 1'b1, 2'd0},
    {4'b1100, 4'b0100, 1'b1, 2'd2},
    {4'b1111, 4'b1111, 1'b1, 2'd0},
    {4'b1110, 4'b0000, 1'b0, 2'd1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    chk("R1 reset snp", {31'd0, bus_req_snp}, 0);
    chk("R1 reset plain", {31'd0, bus_req_plain}, 0);
    chk("R1 reset ack", {28'd0, chan_ack}, 0);

    foreach (VEC[v]) begin
      logic       e_snp;
      logic [1:0] e_win;
      e_snp = VEC[v][2];
      e_win = VEC[v][1:0];
      chan_req  = VEC[v][10:7];
      snoop_sel = VEC[v][6:3];
      tick();
      chk("R2/R3/R4/R5 snp req", {31'd0, bus_req_snp}, {31'd0, e_snp});
      chk("R2/R3/R4/R5 plain req", {31'd0, bus_req_plain}, {31'd0, ~e_snp});
      chk("R10 no ack before grant", {28'd0, chan_ack}, 0);
      bus_grant = 1'b1;
      tick();
      chk("R3 R6 ack winner", {28'd0, chan_ack}, 32'd1 << e_win);
      bus_grant = 1'b0;
      chan_req  = '0;
      tick();
      chk("R6 ack single cycle", {28'd0, chan_ack}, 0);
      chk("R5 request held", {31'd0, bus_req_snp | bus_req_plain}, 1);
      xfer_done = 4'd1 << e_win;
      tick();
      xfer_done = '0;
      chk("R9 request dropped", {31'd0, bus_req_snp | bus_req_plain}, 0);
      tick();
    end

    // No grant, cross-type blocking, foreign done, gap
    chan_req  = 4'b0100;
    snoop_sel = 4'b0000;
    tick();
    chk("R2 plain req", {31'd0, bus_req_plain}, 1);
    chan_req = 4'b0000;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10 no ack without grant", {28'd0, chan_ack}, 0);
      chk("R5 held waiting grant", {31'd0, bus_req_plain}, 1);
    end
    chan_req  = 4'b0001;
    snoop_sel = 4'b0001;
    tick();
    chk("R7 other type blocked", {31'd0, bus_req_snp}, 0);
    bus_grant = 1'b1;
    tick();
    bus_grant = 1'b0;
    chk("R7 ack keeps winner", {28'd0, chan_ack}, 32'h4);
    xfer_done = 4'b0001;
    tick();
    xfer_done = '0;
    chk("R8 foreign done ignored", {31'd0, bus_req_plain}, 1);
    chk("R7 snp still low", {31'd0, bus_req_snp}, 0);
    xfer_done = 4'b0100;
    tick();
    xfer_done = '0;
    chk("R9 fall on done", {31'd0, bus_req_plain}, 0);
    tick();
    chk("R9 gap cycle", {31'd0, bus_req_snp | bus_req_plain}, 0);
    tick();
    chk("R4 pending snoop wins after gap", {31'd0, bus_req_snp}, 1);

    // Reset during a transfer
    rst = 1'b1;
    chan_req = '0;
    tick();
    chk("R1 mid reset snp", {31'd0, bus_req_snp}, 0);
    chk("R1 mid reset plain", {31'd0, bus_req_plain}, 0);
    chk("R1 mid reset ack", {28'd0, chan_ack}, 0);
    rst = 1'b0;
    tick();
    chk("R1 idle after reset", {31'd0, bus_req_snp | bus_req_plain}, 0);

    summary();
  end
endmodule